// File: doc/BRIEF.md
# Memory-Mapped Interrupt Unit

This block sits on a processor's memory-mapped bus and decides when the core is interrupted. Peripheral request lines come in raw and are visible as a read-only pending word. A software mask selects which lines may interrupt. A global enable bit gates everything. When the unit raises its request and the core acknowledges it, the enable bit drops by itself and the program counter of the instruction that had not yet committed is latched. A handler can later read it back and jump to it, so that instruction runs again.

There is one handler entry point, held in a writable register, and it is offered to the core at all times. Choosing among several active sources is left to software. When software sets the enable bit again on leaving a handler, requests stay held off for a fixed number of cycles. This lets the return jump finish before a new interrupt can be taken.

Top module: `irq_unit`

## Requirements
- R1: After reset the handler register holds the parameter `VEC_RESET`, and the mask, the enable bit and the saved PC all read 0. `irq_req` is low.
- R2: The handler register is read/write at byte offset 0x00. Its value drives `handler_addr` continuously.
- R3: Byte offset 0x04 reads the current `irq_lines`, zero-extended. Writes to it have no effect.
- R4: The mask is read/write at offset 0x08 (low `NSRC` bits). `irq_req` is high exactly when the enable bit is 1, the hold-off count is 0, and `irq_lines & mask` is nonzero.
- R5: The enable bit is bit 0 at offset 0x0C and is read and written by software. Writing 0 clears it.
- R6: A write of 1 to the enable bit starts a hold-off of `SETTLE` (default 3) cycles. `irq_req` stays low for the first `SETTLE` cycles after that write's clock edge. It can rise no earlier than `SETTLE` edges later.
- R7: At a clock edge where `irq_req` and `core_ack` are both high, the enable bit is cleared and the saved PC takes `core_pc`.
- R8: The saved PC reads at offset 0x10. Bus writes to it have no effect, and it changes only on acceptance.
- R9: If a bus write to the enable bit happens on the same edge as an acceptance, the acceptance wins: the bit ends up 0 and no hold-off starts.
- R10: Reads from any other word offset return 0, and writes there change nothing. Address bits [1:0] are ignored. Read data is combinational from `bus_addr` and does not depend on `bus_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when strobed |
| bus_addr | input | ADDR_W | Byte address inside the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_lines | input | NSRC | Peripheral request lines |
| core_pc | input | 32 | PC of the oldest uncommitted instruction |
| core_ack | input | 1 | Core takes the pending interrupt this cycle |
| irq_req | output | 1 | Interrupt request to the core |
| handler_addr | output | 32 | Handler entry address |

## Verification
Several properties are checked on every cycle. After each acceptance the enable bit is clear and the saved PC equals the PC of the previous cycle. The saved PC never moves without an acceptance. A request never appears without the enable bit and an unmasked pending line. The enable bit's rising cycle never carries a request. The exact length of the hold-off, the register map with its ignored writes, the collision between a software set and an acceptance, and the reset values are shown only by the bench. It runs directed scenarios and a seeded random run against a cycle model.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int DATA_W    = 32;
  // word indices (byte offset / 4)
  localparam int WIDX_VEC  = 0;
  localparam int WIDX_PEND = 1;
  localparam int WIDX_MASK = 2;
  localparam int WIDX_EN   = 3;
  localparam int WIDX_EPC  = 4;
endpackage

// File: rtl/irq_unit_regs.sv
module irq_unit_regs
  import irq_unit_pkg::*;
#(
  parameter int          NSRC      = 8,
  parameter logic [31:0] VEC_RESET = 32'h0000_0100,
  parameter int          SETTLE    = 3,
  localparam int         CW        = $clog2(SETTLE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vec,
  input  logic              wr_mask,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              accept,
  input  logic [DATA_W-1:0] core_pc,
  output logic [DATA_W-1:0] vec_q,
  output logic [NSRC-1:0]   mask_q,
  output logic              en_q,
  output logic [CW-1:0]     hold_q,
  output logic [DATA_W-1:0] epc_q
);
  logic [DATA_W-1:0] vec_d, epc_d;
  logic [NSRC-1:0]   mask_d;
  logic              en_d;
  logic [CW-1:0]     hold_d;

  always_comb begin
    vec_d  = wr_vec  ? wdata : vec_q;
    mask_d = wr_mask ? wdata[NSRC-1:0] : mask_q;
    epc_d  = accept  ? core_pc : epc_q;
    en_d   = en_q;
    hold_d = (hold_q != '0) ? hold_q - CW'(1) : hold_q;
    if (accept) begin
      en_d = 1'b0;
    end else if (wr_en) begin
      en_d = wdata[0];
      if (wdata[0]) hold_d = CW'(SETTLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= VEC_RESET;
      mask_q <= '0;
      en_q   <= 1'b0;
      hold_q <= '0;
      epc_q  <= '0;
    end else begin
      vec_q  <= vec_d;
      mask_q <= mask_d;
      en_q   <= en_d;
      hold_q <= hold_d;
      epc_q  <= epc_d;
    end
  end
endmodule

// File: rtl/irq_unit_bus.sv
module irq_unit_bus
  import irq_unit_pkg::*;
#(
  parameter int  NSRC   = 8,
  parameter int  ADDR_W = 8,
  localparam int IW     = ADDR_W - 2
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] vec_q,
  input  logic [NSRC-1:0]   pend,
  input  logic [NSRC-1:0]   mask_q,
  input  logic              en_q,
  input  logic [DATA_W-1:0] epc_q,
  output logic              wr_vec,
  output logic              wr_mask,
  output logic              wr_en,
  output logic [DATA_W-1:0] rdata
);
  logic [IW-1:0] idx;
  logic          wr;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign wr      = bus_sel & bus_we;
  assign wr_vec  = wr & (idx == IW'(WIDX_VEC));
  assign wr_mask = wr & (idx == IW'(WIDX_MASK));
  assign wr_en   = wr & (idx == IW'(WIDX_EN));

  always_comb begin
    rdata = '0;
    if (idx == IW'(WIDX_VEC))       rdata = vec_q;
    else if (idx == IW'(WIDX_PEND)) rdata = {{(DATA_W-NSRC){1'b0}}, pend};
    else if (idx == IW'(WIDX_MASK)) rdata = {{(DATA_W-NSRC){1'b0}}, mask_q};
    else if (idx == IW'(WIDX_EN))   rdata = {{(DATA_W-1){1'b0}}, en_q};
    else if (idx == IW'(WIDX_EPC))  rdata = epc_q;
  end
endmodule

// File: rtl/irq_unit_req.sv
module irq_unit_req #(
  parameter int NSRC = 8,
  parameter int CW   = 2
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] mask_q,
  input  logic            en_q,
  input  logic [CW-1:0]   hold_q,
  output logic            irq_req
);
  assign irq_req = en_q & (hold_q == '0) & (|(pend & mask_q));
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_unit_pkg::*;
#(
  parameter int          NSRC      = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] VEC_RESET = 32'h0000_0100,
  parameter int          SETTLE    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   irq_lines,
  input  logic [31:0]       core_pc,
  input  logic              core_ack,
  output logic              irq_req,
  output logic [31:0]       handler_addr
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [DATA_W-1:0] vec_q, epc_q;
  logic [NSRC-1:0]   mask_q;
  logic              en_q, wr_vec, wr_mask, wr_en, accept;
  logic [CW-1:0]     hold_q;

  assign accept       = irq_req & core_ack;
  assign handler_addr = vec_q;

  irq_unit_regs #(.NSRC(NSRC), .VEC_RESET(VEC_RESET), .SETTLE(SETTLE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_vec(wr_vec), .wr_mask(wr_mask), .wr_en(wr_en),
    .wdata(bus_wdata), .accept(accept), .core_pc(core_pc),
    .vec_q(vec_q), .mask_q(mask_q), .en_q(en_q), .hold_q(hold_q), .epc_q(epc_q)
  );

  irq_unit_bus #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_bus (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .vec_q(vec_q), .pend(irq_lines), .mask_q(mask_q), .en_q(en_q), .epc_q(epc_q),
    .wr_vec(wr_vec), .wr_mask(wr_mask), .wr_en(wr_en), .rdata(bus_rdata)
  );

  irq_unit_req #(.NSRC(NSRC), .CW(CW)) u_req (
    .pend(irq_lines), .mask_q(mask_q), .en_q(en_q), .hold_q(hold_q), .irq_req(irq_req)
  );
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_lines,
  input logic [NSRC-1:0] mask_q,
  input logic            en_q,
  input logic [31:0]     epc_q,
  input logic [31:0]     core_pc,
  input logic            core_ack,
  input logic            irq_req
);
  // R7
  accept_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && core_ack) |=> !en_q);
  // R7
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && core_ack) |=> (epc_q == $past(core_pc)));
  // R8
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_req && core_ack) |=> $stable(epc_q));
  // R4
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en_q && ((irq_lines & mask_q) != '0)));
  // R6
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> !irq_req);
endmodule

bind irq_unit irq_unit_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .mask_q(mask_q), .en_q(en_q),
  .epc_q(epc_q), .core_pc(core_pc), .core_ack(core_ack), .irq_req(irq_req)
);

// File: tb/tb_irq_unit.sv
module tb_irq_unit;
  localparam int          CLK_PERIOD = 10;
  localparam int          NSRC       = 8;
  localparam int          ADDR_W     = 8;
  localparam logic [31:0] VEC_RST    = 32'h0000_0100;
  localparam int          SETTLE     = 3;

  logic              clk, rst_n, bus_sel, bus_we, core_ack;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata, core_pc, handler_addr;
  logic [NSRC-1:0]   irq_lines;
  logic              irq_req;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [31:0]     m_vec, m_epc;
  logic [NSRC-1:0] m_mask;
  logic            m_en;
  int              m_hold;

  irq_unit #(.NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_RESET(VEC_RST), .SETTLE(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .core_pc(core_pc), .core_ack(core_ack), .irq_req(irq_req), .handler_addr(handler_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return m_en && (m_hold == 0) && ((irq_lines & m_mask) != '0);
  endfunction

  function automatic logic [31:0] exp_rd(logic [ADDR_W-1:0] a);
    case (int'(a[ADDR_W-1:2]))
      0: return m_vec;
      1: return {{(32-NSRC){1'b0}}, irq_lines};
      2: return {{(32-NSRC){1'b0}}, m_mask};
      3: return {31'b0, m_en};
      4: return m_epc;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(logic [ADDR_W-1:0] a);
    case (int'(a[ADDR_W-1:2]))
      0: return "R2 read handler";
      1: return "R3 read pending";
      2: return "R4 read mask";
      3: return "R5 read enable";
      4: return "R8 read saved pc";
      default: return "R10 read unmapped";
    endcase
  endfunction

  // one cycle: inputs already driven after a falling edge
  task automatic cyc();
    logic acc;
    int   wi;
    #1;
    chk("R4 irq_req", {31'b0, irq_req}, {31'b0, exp_irq()});
    chk("R2 handler_addr", handler_addr, m_vec);
    chk(rd_tag(bus_addr), bus_rdata, exp_rd(bus_addr));
    acc = exp_irq() && core_ack;
    wi  = (bus_sel && bus_we) ? int'(bus_addr[ADDR_W-1:2]) : -1;
    @(posedge clk);
    if (m_hold != 0) m_hold--;
    if (wi == 0) m_vec  = bus_wdata;
    if (wi == 2) m_mask = bus_wdata[NSRC-1:0];
    if (acc) begin
      m_en  = 1'b0;
      m_epc = core_pc;
    end else if (wi == 3) begin
      m_en = bus_wdata[0];
      if (bus_wdata[0]) m_hold = SETTLE;
    end
    @(negedge clk);
  endtask

  task automatic drive(logic s, logic w, logic [ADDR_W-1:0] a, logic [31:0] d, logic k);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; core_ack = k;
    cyc();
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 8'h0C, 32'h0, 1'b0);
  endtask

  task automatic peek(string tag, logic [ADDR_W-1:0] a, logic [31:0] exp);
    bus_sel = 1'b0; bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    irq_lines = '0; core_pc = '0; core_ack = 0;
    m_vec = VEC_RST; m_epc = '0; m_mask = '0; m_en = 0; m_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek("R1 handler reset", 8'h00, VEC_RST);
    peek("R1 mask reset", 8'h08, 32'h0);
    peek("R1 enable reset", 8'h0C, 32'h0);
    peek("R1 saved pc reset", 8'h10, 32'h0);
    chk("R1 irq_req reset", {31'b0, irq_req}, 32'h0);
    // R2 handler write
    drive(1, 1, 8'h00, 32'hCAFE_0040, 0);
    chk("R2 handler written", handler_addr, 32'hCAFE_0040);
    // R3 write to pending ignored
    irq_lines = 8'h04;
    drive(1, 1, 8'h04, 32'hFFFF_FFFF, 0);
    peek("R3 pending after write", 8'h04, 32'h4);
    // R4 mask, R6 hold-off
    drive(1, 1, 8'h08, 32'h0000_0005, 0);
    drive(1, 1, 8'h0C, 32'h1, 0);
    for (int i = 0; i < SETTLE; i++) begin
      #1 chk("R6 hold-off keeps irq low", {31'b0, irq_req}, 32'h0);
      idle();
    end
    #1 chk("R6 irq after hold-off", {31'b0, irq_req}, 32'h1);
    // R7 acceptance
    core_pc = 32'h0000_1234;
    drive(0, 0, 8'h0C, 32'h0, 1);
    peek("R7 enable cleared", 8'h0C, 32'h0);
    peek("R7 saved pc", 8'h10, 32'h0000_1234);
    chk("R7 irq low after accept", {31'b0, irq_req}, 32'h0);
    // R8 write to saved pc ignored
    drive(1, 1, 8'h10, 32'hFFFF_0000, 0);
    peek("R8 saved pc unchanged", 8'h10, 32'h0000_1234);
    // R5 clear by software
    drive(1, 1, 8'h0C, 32'h1, 0);
    drive(1, 1, 8'h0C, 32'h0, 0);
    peek("R5 enable cleared by write", 8'h0C, 32'h0);
    // R9 collision
    drive(1, 1, 8'h0C, 32'h1, 0);
    repeat (SETTLE) idle();
    core_pc = 32'h0000_5678;
    drive(1, 1, 8'h0C, 32'h1, 1);
    peek("R9 accept beats set", 8'h0C, 32'h0);
    peek("R9 saved pc", 8'h10, 32'h0000_5678);
    // R10 unmapped
    drive(1, 1, 8'h18, 32'hDEAD_BEEF, 0);
    peek("R10 unmapped reads zero", 8'h18, 32'h0);
    peek("R10 low addr bits ignored", 8'h03, 32'hCAFE_0040);
    // random run
    for (int n = 0; n < 2000; n++) begin
      logic [ADDR_W-1:0] a;
      a = 8'((($urandom % 7) * 4) | ($urandom % 4));
      irq_lines = NSRC'($urandom);
      core_pc   = $urandom;
      drive(($urandom % 3) == 0, $urandom % 2, a,
            ((a[ADDR_W-1:2] == 3) ? 32'($urandom % 2) : $urandom), ($urandom % 2) == 0);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule